// File: doc/BRIEF.md
# Activity Monitor Counter Bank

This block is a per-core set of 64-bit activity counters for system-management software. Four fixed counters track core cycles, constant-rate reference ticks, retired instructions and cycles lost to last-level-cache misses. A second group holds a configurable number of auxiliary counters, up to sixteen, each driven by its own event strobe. No counter moves while the core is in a wait-for-interrupt or wait-for-event low-power state. A counter also stays still when higher-privilege software has not enabled it.

Software reaches the counters through a single request port. Each request carries a group, an index, a privilege level and an optional write value. The block answers on the next cycle with a result code and the data. The access rules are as follows:

- Reads from user level trap unless user access is permitted.
- Any request made while the guest indicator is high fails as undefined.
- Higher-privilege writes preload a counter.

Top module: `actmon_bank`

## Requirements
- R1: Group 0 (req_group=0) indices 0, 1, 2 and 3 select, in that order, the core-cycle, constant-tick, retired-instruction and cache-stall counters. Group 1 (req_group=1) index k selects auxiliary counter k, driven by ev_aux[k].
- R2: The core-cycle counter gains 1 in each cycle in which ev_core_cyc is high.
- R3: The constant-tick counter gains 1 for each cycle in which the single-cycle pulse ev_const_tick is high.
- R4: The retired-instruction counter adds the 2-bit value ev_inst_ret (0 to 3) in each cycle.
- R5: While in_wait is high, no counter changes value except through a write.
- R6: While rst_n is low, every counter clears to zero and rsp_valid is 0.
- R7: A counter whose enable bit is low (en_fixed[i] or en_aux[k]) does not count, and reads of it return zero. It resumes from its held value once it is enabled again.
- R8: Privilege code 0 is user level. A user-level read returns rsp_err=2'b01 (trap) and zero data unless user_access_en is high. A user-level write always traps and changes nothing.
- R9: A request made while guest_mode is high returns rsp_err=2'b10 (undefined) with zero data, and a write made this way changes nothing.
- R10: A read of group 0 index 4 to 15, or of group 1 index at or above AUX_N, returns zero with rsp_err=2'b00. A write to such an index changes nothing.
- R11: A permitted write (privilege code 1 to 3) loads req_wdata into the addressed counter. This load takes precedence over that cycle's increment. Counters wrap modulo 2^64.
- R12: A request in cycle N yields rsp_valid in cycle N+1, and rsp_valid is low otherwise. The read data is the counter value at the start of cycle N, so it includes none of cycle N's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| ev_core_cyc | input | 1 | Core-cycle strobe |
| ev_const_tick | input | 1 | Reference tick pulse, already synchronized to clk |
| ev_inst_ret | input | 2 | Instructions retired this cycle |
| ev_llc_stall | input | 1 | Stall cycle caused by a last-level-cache miss |
| ev_aux | input | AUX_N | Auxiliary event strobes |
| in_wait | input | 1 | Core is in a low-power wait state |
| en_fixed | input | 4 | Enables for the fixed counters |
| en_aux | input | AUX_N | Enables for the auxiliary counters |
| user_access_en | input | 1 | Allows reads from user level |
| guest_mode | input | 1 | Request comes from a virtual-machine guest |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Requester privilege, 0 = user, 3 = highest |
| req_group | input | 1 | 0 = fixed group, 1 = auxiliary group |
| req_index | input | 4 | Counter index within the group |
| req_wdata | input | 64 | Value to preload |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 2 | 00 ok, 01 trap, 10 undefined |
| rsp_rdata | output | 64 | Read data, zero on error or write |

## Verification
The design has one register stage between the request and the response. Each response therefore belongs to the request driven one clock edge earlier, and its data comes from the bench model before that edge's update. The bench drives each cycle's inputs on the falling edge and predicts the response from its model before the rising edge. It then advances the model by that cycle's events and compares the response on the next falling edge. This keeps the rule that a read excludes its own cycle's increment inside every comparison. A directed series covers each counter, wait gating, enables, wrap and the error codes. A long sweep then mixes events, enables, wait, guest and privilege values, every index of both groups, and writes near the wrap point.

// File: rtl/actmon_pkg.sv
// Package: shared constants and encodings for the activity monitor bank.
// Assumes the index space of each group is 16 slots wide.
package actmon_pkg;
    localparam int FIXED_N = 4;
    localparam int SLOT_N  = 16;
    localparam int IDX_W   = $clog2(SLOT_N);
    localparam int CNT_W   = 64;
    localparam int INST_W  = 2;

    // Slot positions inside the fixed group; software decodes these.
    localparam int SLOT_CORE  = 0;
    localparam int SLOT_CONST = 1;
    localparam int SLOT_INST  = 2;
    localparam int SLOT_STALL = 3;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_MON  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_OK    = 2'b00,
        ACC_TRAP  = 2'b01,
        ACC_UNDEF = 2'b10
    } acc_e;
endpackage

// File: rtl/actmon_counter.sv
// Module: one wrapping counter with an increment amount and a preload.
// Assumes the preload and the increment never act together (the preload wins).
module actmon_counter #(
    parameter int W     = 64,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [INC_W-1:0] step_amt,
    input  logic             load_en,
    input  logic [W-1:0]     load_val,
    output logic [W-1:0]     cnt_q
);
    // Counter state: clear on reset, preload, otherwise step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load_en) cnt_q <= load_val;
        else if (step_en) cnt_q <= cnt_q + W'(step_amt);
    end

    // With no step and no load the value must not move.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/actmon_gate.sv
// Module: turns raw event strobes into per-counter step requests.
// Assumes all strobes are synchronous to clk; the wait state freezes everything.
module actmon_gate
    import actmon_pkg::*;
#(
    parameter int AUX_N = 4
) (
    input  logic                 ev_core_cyc,
    input  logic                 ev_const_tick,
    input  logic [INST_W-1:0]    ev_inst_ret,
    input  logic                 ev_llc_stall,
    input  logic [AUX_N-1:0]     ev_aux,
    input  logic                 in_wait,
    input  logic [FIXED_N-1:0]   en_fixed,
    input  logic [AUX_N-1:0]     en_aux,
    output logic [FIXED_N-1:0]   fix_step,
    output logic [INST_W-1:0]    fix_amt [FIXED_N],
    output logic [AUX_N-1:0]     aux_step
);
    logic [INST_W-1:0] raw_amt [FIXED_N];

    // Map each event source to its slot as an increment amount.
    always_comb begin
        raw_amt[SLOT_CORE]  = INST_W'(ev_core_cyc);
        raw_amt[SLOT_CONST] = INST_W'(ev_const_tick);
        raw_amt[SLOT_INST]  = ev_inst_ret;
        raw_amt[SLOT_STALL] = INST_W'(ev_llc_stall);
    end

    for (genvar i = 0; i < FIXED_N; i++) begin : g_fix
        // A fixed counter steps when enabled, awake and its event is non-zero.
        always_comb begin
            fix_step[i] = en_fixed[i] && !in_wait && (raw_amt[i] != '0);
            fix_amt[i]  = raw_amt[i];
        end
    end

    // Auxiliary counters step by one on their own strobe.
    always_comb aux_step = en_aux & ev_aux & {AUX_N{!in_wait}};
endmodule

// File: rtl/actmon_access.sv
// Module: checks requests against privilege and guest state, decodes the
// target, muxes read data and registers the one-cycle response.
// Assumes counter values presented are those before this cycle's update.
module actmon_access
    import actmon_pkg::*;
#(
    parameter int AUX_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               user_access_en,
    input  logic               guest_mode,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_priv,
    input  logic               req_group,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [FIXED_N-1:0] en_fixed,
    input  logic [AUX_N-1:0]   en_aux,
    input  logic [CNT_W-1:0]   fix_val [FIXED_N],
    input  logic [CNT_W-1:0]   aux_val [AUX_N],
    output logic [FIXED_N-1:0] fix_load,
    output logic [AUX_N-1:0]   aux_load,
    output logic               rsp_valid,
    output logic [1:0]         rsp_err,
    output logic [CNT_W-1:0]   rsp_rdata
);
    acc_e              verdict;
    logic              granted;
    logic [CNT_W-1:0]  rd_mux;

    // Decide the result code: guest first, then user-level restrictions.
    always_comb begin
        if (guest_mode)
            verdict = ACC_UNDEF;
        else if (priv_e'(req_priv) == PRIV_USER && (req_write || !user_access_en))
            verdict = ACC_TRAP;
        else
            verdict = ACC_OK;
        granted = req_valid && (verdict == ACC_OK);
    end

    // Decode the target slot into load strobes and a read value.
    always_comb begin
        fix_load = '0;
        aux_load = '0;
        rd_mux   = '0;
        for (int i = 0; i < FIXED_N; i++) begin
            if (!req_group && req_index == IDX_W'(i)) begin
                fix_load[i] = granted && req_write;
                if (en_fixed[i]) rd_mux = fix_val[i];
            end
        end
        for (int k = 0; k < AUX_N; k++) begin
            if (req_group && req_index == IDX_W'(k)) begin
                aux_load[k] = granted && req_write;
                if (en_aux[k]) rd_mux = aux_val[k];
            end
        end
    end

    // Response register: code and data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= ACC_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid ? verdict : ACC_OK;
            rsp_rdata <= (granted && !req_write) ? rd_mux : '0;
        end
    end

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_guest_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && guest_mode) |=> (rsp_err == ACC_UNDEF && rsp_rdata == '0));
    assert_user_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guest_mode && req_priv == 2'd0 && !user_access_en)
        |=> (rsp_err == ACC_TRAP && rsp_rdata == '0));
    assert_one_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fix_load, aux_load}) <= 1);
endmodule

// File: rtl/actmon_bank.sv
// Module: top of the activity monitor bank: four fixed counters, AUX_N
// auxiliary counters, event gating and the checked request port.
// Assumes AUX_N lies between 1 and 16 and all inputs are synchronous to clk.
module actmon_bank
    import actmon_pkg::*;
#(
    parameter int AUX_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_core_cyc,
    input  logic               ev_const_tick,
    input  logic [1:0]         ev_inst_ret,
    input  logic               ev_llc_stall,
    input  logic [AUX_N-1:0]   ev_aux,
    input  logic               in_wait,
    input  logic [3:0]         en_fixed,
    input  logic [AUX_N-1:0]   en_aux,
    input  logic               user_access_en,
    input  logic               guest_mode,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_priv,
    input  logic               req_group,
    input  logic [3:0]         req_index,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [1:0]         rsp_err,
    output logic [63:0]        rsp_rdata
);
    logic [FIXED_N-1:0] fix_step;
    logic [INST_W-1:0]  fix_amt  [FIXED_N];
    logic [AUX_N-1:0]   aux_step;
    logic [FIXED_N-1:0] fix_load;
    logic [AUX_N-1:0]   aux_load;
    logic [CNT_W-1:0]   fix_val  [FIXED_N];
    logic [CNT_W-1:0]   aux_val  [AUX_N];

    actmon_gate #(.AUX_N(AUX_N)) gate_i (
        .ev_core_cyc  (ev_core_cyc),
        .ev_const_tick(ev_const_tick),
        .ev_inst_ret  (ev_inst_ret),
        .ev_llc_stall (ev_llc_stall),
        .ev_aux       (ev_aux),
        .in_wait      (in_wait),
        .en_fixed     (en_fixed),
        .en_aux       (en_aux),
        .fix_step     (fix_step),
        .fix_amt      (fix_amt),
        .aux_step     (aux_step)
    );

    for (genvar i = 0; i < FIXED_N; i++) begin : g_fixed
        actmon_counter #(.W(CNT_W), .INC_W(INST_W)) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (fix_step[i]),
            .step_amt(fix_amt[i]),
            .load_en (fix_load[i]),
            .load_val(req_wdata),
            .cnt_q   (fix_val[i])
        );
        assert_wait_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_wait && !fix_load[i]) |=> $stable(fix_val[i]));
    end

    for (genvar k = 0; k < AUX_N; k++) begin : g_aux
        actmon_counter #(.W(CNT_W), .INC_W(1)) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (aux_step[k]),
            .step_amt(1'b1),
            .load_en (aux_load[k]),
            .load_val(req_wdata),
            .cnt_q   (aux_val[k])
        );
        assert_wait_freeze_aux_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_wait && !aux_load[k]) |=> $stable(aux_val[k]));
    end

    actmon_access #(.AUX_N(AUX_N)) access_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .user_access_en(user_access_en),
        .guest_mode    (guest_mode),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_priv      (req_priv),
        .req_group     (req_group),
        .req_index     (req_index),
        .en_fixed      (en_fixed),
        .en_aux        (en_aux),
        .fix_val       (fix_val),
        .aux_val       (aux_val),
        .fix_load      (fix_load),
        .aux_load      (aux_load),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata)
    );
endmodule

// File: tb/actmon_bank_tb_top.sv
// Bench: directed series plus a long mixed sweep against an arithmetic model.
module actmon_bank_tb_top;
    localparam int CLK_P = 10;
    localparam int AUXN  = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic ev_core_cyc, ev_const_tick, ev_llc_stall, in_wait;
    logic [1:0] ev_inst_ret;
    logic [AUXN-1:0] ev_aux, en_aux;
    logic [3:0] en_fixed;
    logic user_access_en, guest_mode;
    logic req_valid, req_write, req_group;
    logic [1:0] req_priv;
    logic [3:0] req_index;
    logic [63:0] req_wdata;
    logic rsp_valid;
    logic [1:0] rsp_err;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [63:0] m_fix [4];
    logic [63:0] m_aux [AUXN];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    actmon_bank #(.AUX_N(AUXN)) dut_i (.*);

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic idle_inputs();
        ev_core_cyc = 0; ev_const_tick = 0; ev_inst_ret = 0; ev_llc_stall = 0;
        ev_aux = '0; in_wait = 0; req_valid = 0; req_write = 0; req_group = 0;
        req_priv = 2'd1; req_index = 0; req_wdata = '0; guest_mode = 0;
    endtask

    task automatic set_read(input logic grp, input logic [3:0] idx, input logic [1:0] pv);
        req_valid = 1; req_write = 0; req_group = grp; req_index = idx; req_priv = pv;
    endtask

    // One clock: predict, advance the model at the edge, compare afterwards.
    task automatic cycle(input string tag);
        logic ev; logic [1:0] ee; logic [63:0] ed;
        logic impl, en, wr_ok;
        string t;
        impl = req_group ? (req_index < AUXN) : (req_index < 4);
        en = impl && (req_group ? en_aux[req_index[1:0]] : en_fixed[req_index[1:0]]);
        ev = req_valid; ee = 2'b00; ed = '0; wr_ok = 0;
        if (guest_mode) ee = 2'b10;
        else if (req_priv == 2'd0 && (req_write || !user_access_en)) ee = 2'b01;
        else if (req_write) wr_ok = req_valid && impl;
        else if (en) ed = req_group ? m_aux[req_index[1:0]] : m_fix[req_index[1:0]];
        t = tag;
        if (t == "") begin
            if (!req_valid) t = "R12";
            else if (guest_mode) t = "R9";
            else if (ee == 2'b01) t = "R8";
            else if (!impl) t = "R10";
            else if (req_write) t = "R11";
            else if (!en) t = "R7";
            else t = "R12";
        end
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            logic [1:0] a;
            a = (i == 0) ? {1'b0, ev_core_cyc} : (i == 1) ? {1'b0, ev_const_tick} :
                (i == 2) ? ev_inst_ret : {1'b0, ev_llc_stall};
            if (wr_ok && !req_group && req_index == 4'(i)) m_fix[i] = req_wdata;
            else if (en_fixed[i] && !in_wait) m_fix[i] = m_fix[i] + 64'(a);
        end
        for (int k = 0; k < AUXN; k++) begin
            if (wr_ok && req_group && req_index == 4'(k)) m_aux[k] = req_wdata;
            else if (en_aux[k] && !in_wait && ev_aux[k]) m_aux[k] = m_aux[k] + 64'd1;
        end
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== ev || (ev && (rsp_err !== ee || rsp_rdata !== ed))) begin
            n_fails++;
            $display("FAIL %s: got v=%0b err=%0b data=%h, expected v=%0b err=%0b data=%h",
                     t, rsp_valid, rsp_err, rsp_rdata, ev, ee, ed);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        en_fixed = 4'hF; en_aux = '1; user_access_en = 0; rst_n = 0;
        for (int i = 0; i < 4; i++) m_fix[i] = '0;
        for (int k = 0; k < AUXN; k++) m_aux[k] = '0;
        // R6: events are ignored and no response appears while reset is held.
        ev_core_cyc = 1; ev_inst_ret = 3; ev_aux = '1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++; $display("FAIL R6: got rsp_valid=%0b, expected 0", rsp_valid);
        end
        idle_inputs(); rst_n = 1;
        for (int i = 0; i < 4; i++) begin set_read(0, 4'(i), 2'd1); cycle("R6"); end
        for (int k = 0; k < AUXN; k++) begin set_read(1, 4'(k), 2'd3); cycle("R6"); end

        // R2: core strobe for five cycles, then read every fixed slot (R1 order).
        idle_inputs(); ev_core_cyc = 1;
        repeat (5) cycle("R2");
        idle_inputs();
        set_read(0, 0, 2'd1); cycle("R2");
        for (int i = 1; i < 4; i++) begin set_read(0, 4'(i), 2'd1); cycle("R1"); end
        // R3: three separate tick pulses.
        for (int j = 0; j < 3; j++) begin
            idle_inputs(); ev_const_tick = 1; cycle("R3");
            idle_inputs(); cycle("R3");
        end
        set_read(0, 1, 2'd2); cycle("R3");
        // R4: per-cycle instruction counts of every value.
        for (int j = 0; j < 8; j++) begin
            idle_inputs(); ev_inst_ret = 2'(j); cycle("R4");
        end
        idle_inputs(); set_read(0, 2, 2'd1); cycle("R4");
        // R1: stall counter and one auxiliary counter.
        idle_inputs(); ev_llc_stall = 1; ev_aux = 4'b0100; cycle("R1"); cycle("R1");
        idle_inputs(); set_read(0, 3, 2'd1); cycle("R1");
        set_read(1, 2, 2'd1); cycle("R1");
        // R5: wait freezes everything.
        idle_inputs(); in_wait = 1; ev_core_cyc = 1; ev_const_tick = 1; ev_inst_ret = 3;
        ev_llc_stall = 1; ev_aux = '1;
        repeat (6) cycle("R5");
        for (int i = 0; i < 4; i++) begin set_read(0, 4'(i), 2'd1); cycle("R5"); end
        set_read(1, 0, 2'd1); cycle("R5");
        // R7: disabled core counter holds, reads zero, then resumes.
        idle_inputs(); en_fixed = 4'b1110; ev_core_cyc = 1;
        repeat (4) cycle("R7");
        set_read(0, 0, 2'd1); cycle("R7");
        idle_inputs(); en_fixed = 4'hF; set_read(0, 0, 2'd1); cycle("R7");
        // R11: preload near the top and wrap through zero.
        idle_inputs(); req_valid = 1; req_write = 1; req_priv = 2'd1; req_index = 2;
        req_wdata = 64'hFFFF_FFFF_FFFF_FFFE; ev_inst_ret = 3; cycle("R11");
        idle_inputs(); ev_inst_ret = 3; cycle("R11");
        idle_inputs(); set_read(0, 2, 2'd1); cycle("R11");
        // R12: a read in a counting cycle shows the value from before it.
        idle_inputs(); ev_core_cyc = 1; set_read(0, 0, 2'd1); cycle("R12");
        idle_inputs(); set_read(0, 0, 2'd1); cycle("R12");
        // R8: user read traps, then succeeds; user write never lands.
        idle_inputs(); set_read(0, 0, 2'd0); cycle("R8");
        user_access_en = 1; cycle("R8");
        req_write = 1; req_wdata = 64'd77; cycle("R8");
        idle_inputs(); set_read(0, 0, 2'd1); cycle("R8");
        // R9: guest read and write both fail; the write has no effect.
        idle_inputs(); guest_mode = 1; set_read(0, 1, 2'd3); cycle("R9");
        req_write = 1; req_wdata = 64'd5; cycle("R9");
        idle_inputs(); set_read(0, 1, 2'd1); cycle("R9");
        // R10: unimplemented slots read zero; writes there are dropped.
        idle_inputs(); set_read(0, 4'd9, 2'd1); cycle("R10");
        set_read(1, 4'd12, 2'd1); cycle("R10");
        req_write = 1; req_wdata = 64'd3; cycle("R10");
        idle_inputs(); set_read(1, 4'd0, 2'd1); cycle("R10");

        // Mixed sweep over every index, privilege and gating combination.
        for (int c = 0; c < 6000; c++) begin
            logic [31:0] r;
            r = rnd();
            ev_core_cyc = r[0]; ev_const_tick = r[1] & r[2]; ev_inst_ret = r[4:3];
            ev_llc_stall = r[5]; ev_aux = r[9:6]; in_wait = (r[12:10] == 3'd0);
            if (c % 64 == 0) begin en_fixed = r[16:13]; en_aux = r[20:17]; end
            user_access_en = r[21]; guest_mode = (r[25:22] == 4'd0);
            r = rnd();
            req_valid = r[0] | r[1]; req_write = (r[4:2] == 3'd0);
            req_priv = r[6:5]; req_group = r[7]; req_index = r[11:8];
            req_wdata = r[12] ? {60'hFFFF_FFFF_FFFF_FFF, r[16:13]} : {32'd0, rnd()};
            cycle("");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule